// File: doc/BRIEF.md
# Shared-Bus Controller for a Two-Flash plus PSRAM Stack

This block sits on the host side of one 16-bit memory bus. That bus is shared by three stacked dies: a lower flash die, an upper flash die and a pseudo-static RAM. The host issues one request at a time. Each request carries a region, a word address, the direction, byte enables, a flag that marks the first half of a two-cycle flash command, a flag for a configuration write, a burst flag and a word count for reads. The block checks the request and turns it into per-die select and output strobes, plus shared write strobe, address and data. It returns one response per word, or a single error response.

The block has four jobs beyond translating strobes. It never selects two dies at once, and it leaves one fully deselected cycle between two different dies. It keeps both halves of a flash command on one die. It ends a sequential read at the top of the lower flash die and restarts it at word 0 of the upper die. It drives the shared flash reset. It also keeps a shadow of each die's wait-polarity bit, so that the shared WAIT line is read with the polarity of the die that is active. WAIT is honoured only during burst reads.

Top module: `memstack_bus_ctrl`

## Requirements
- R1: At most one of `f_ce1_n`, `f_ce2_n`, `r_ce_n` is low in any cycle.
- R2: When the selected die changes, at least one cycle with all three selects high separates the two selections.
- R3: Region 0 selects the lower flash die and region 1 the upper one (each 2^AW words), and region 2 selects the RAM. A flash read drives that die's select and output enable low with `f_we_n` and `f_rst_n` high. A RAM read drives `r_ce_n`, `r_oe_n`, `r_ub_n` and `r_lb_n` low, with `r_cre` low and `r_we_n` high. Read data is returned in word order.
- R4: A write drives the die's write strobe low and its output enable high, places `req_wdata` on `dq_out` with `dq_oe` high, and presents the address on `mem_addr`. On a RAM write `r_ub_n` is the inverse of `req_be[1]` and `r_lb_n` the inverse of `req_be[0]`.
- R5: Region 3, or a read whose words run past the end of the region's space (2^(AW+1) words for the flash pair, counted from the start of the lower die), returns one response with `rsp_err` high and no die selected.
- R6: After a flash write marked `req_cmd`, a flash write to the other flash die is rejected with an error. A write to the same die is issued and completes the pair. A rejected write leaves the pending pair in place.
- R7: A multi-word read that passes the last word of the lower flash die continues at word 0 of the upper die, after one all-deselected cycle, with no word lost or repeated.
- R8: `f_rst_n` goes low the cycle after `flash_reset` rises. While it is low, both flash selects and `f_we_n` stay high, flash requests return an error, an in-progress flash access ends with an error response, and any pending command pair is dropped. RAM requests proceed as normal.
- R9: The wait-polarity shadows reset to 0 (active-low) for both flash dies and 1 (active-high) for the RAM. An accepted configuration write to a die loads bit 10 of its data into that die's shadow. `cfg_mismatch` is high whenever the shadows do not all agree.
- R10: During a burst read, WAIT at the active die's active level holds the access. In non-burst accesses WAIT has no effect on timing: a single-word read returns its data ACC_CYC+1 cycles after acceptance.
- R11: With RAM_ABITS below AW, RAM addresses of 2^RAM_ABITS and above (or runs that reach past it) return an error, and the unused upper address bits on `mem_addr` are 0 during RAM access.
- R12: After reset `req_ready` is high, all selects and write strobes are high, `f_rst_n` is high and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_region | input | 2 | 0 lower flash, 1 upper flash, 2 RAM, 3 reserved |
| req_addr | input | AW | Word address within the die |
| req_write | input | 1 | 1 write, 0 read |
| req_cmd | input | 1 | Write is the first half of a two-cycle flash command |
| req_cfg | input | 1 | Write targets the die's configuration register |
| req_burst | input | 1 | Read is a burst read (WAIT honoured) |
| req_len | input | LEN_W | Read word count (0 treated as 1) |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DW | Read word |
| flash_reset | input | 1 | Host request to hold both flash dies in reset |
| f_ce1_n | output | 1 | Lower flash select |
| f_ce2_n | output | 1 | Upper flash select |
| f_oe1_n | output | 1 | Lower flash output enable |
| f_oe2_n | output | 1 | Upper flash output enable |
| f_we_n | output | 1 | Shared flash write strobe |
| f_rst_n | output | 1 | Shared flash reset |
| r_ce_n | output | 1 | RAM select |
| r_cre | output | 1 | RAM configuration access enable |
| r_oe_n | output | 1 | RAM output enable |
| r_we_n | output | 1 | RAM write strobe |
| r_ub_n | output | 1 | RAM upper byte lane |
| r_lb_n | output | 1 | RAM lower byte lane |
| mem_addr | output | AW | Shared address |
| dq_out | output | DW | Data driven onto the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | DW | Data read from the bus |
| mem_wait | input | 1 | Raw shared WAIT line |
| wait_active | output | 1 | WAIT is asserting for the active burst |
| cfg_mismatch | output | 1 | Wait-polarity shadows disagree |

## Verification
The most delicate overlap comes when a burst read reaches the die boundary while WAIT is asserting. The hold from WAIT and the handover to the next die then fall into the same stretch of cycles. The bench provokes this with a two-word burst read that starts on the last word of the lower flash die, with WAIT held at its active level over the first cycles. It judges the result by the data of both words, the restart at word 0 of the upper die, and a bus monitor that counts any cycle where two dies are selected or one die follows another without a deselected cycle. A second overlap, a flash reset arriving while a burst is held by WAIT, is checked for an error response and for flash selects that stay high.

// File: rtl/msb_pkg.sv
package msb_pkg;

  typedef enum logic [1:0] {
    DIE_F1   = 2'd0,
    DIE_F2   = 2'd1,
    DIE_RAM  = 2'd2,
    DIE_NONE = 2'd3
  } die_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_SPLIT = 2'd2
  } st_e;

  // true when [start, start+count) lies inside [0, limit)
  function automatic logic span_fits(input logic [23:0] start,
                                     input logic [23:0] count,
                                     input logic [24:0] limit);
    logic [24:0] stop;
    stop = {1'b0, start} + {1'b0, count};
    return stop <= limit;
  endfunction

  function automatic logic is_flash(input die_e d);
    return (d == DIE_F1) || (d == DIE_F2);
  endfunction

  // words a request moves on the bus
  function automatic logic [23:0] word_count(input logic wr, input logic [23:0] len);
    return (wr || len == 24'd0) ? 24'd1 : len;
  endfunction

endpackage

// File: rtl/msb_req_check.sv
module msb_req_check
  import msb_pkg::*;
#(
  parameter int AW        = 22,
  parameter int LEN_W     = 8,
  parameter int RAM_ABITS = 21
) (
  input  logic [1:0]       region,
  input  logic [AW-1:0]    addr,
  input  logic             write,
  input  logic [LEN_W-1:0] len,
  input  logic             pend_valid,
  input  die_e             pend_die,
  input  logic             flash_held,
  output die_e             die,
  output logic             err
);
  localparam logic [24:0] FLASH_LIMIT = 25'(1) << (AW + 1);
  localparam logic [24:0] RAM_LIMIT   = 25'(1) << RAM_ABITS;
  localparam logic [23:0] UPPER_BASE  = 24'(1) << AW;

  logic [23:0] start;
  logic [24:0] limit;
  logic [23:0] count;

  always_comb begin
    die   = DIE_NONE;
    start = '0;
    limit = '0;
    count = word_count(write, 24'(len));
    case (region)
      2'd0: begin die = DIE_F1;  start = 24'(addr);              limit = FLASH_LIMIT; end
      2'd1: begin die = DIE_F2;  start = 24'(addr) + UPPER_BASE; limit = FLASH_LIMIT; end
      2'd2: begin die = DIE_RAM; start = 24'(addr);              limit = RAM_LIMIT;   end
      default: die = DIE_NONE;
    endcase
    err = (die == DIE_NONE) || !span_fits(start, count, limit);
    if (is_flash(die) && flash_held) err = 1'b1;
    if (is_flash(die) && write && pend_valid && (die != pend_die)) err = 1'b1;
  end
endmodule

// File: rtl/msb_pair_track.sv
module msb_pair_track
  import msb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fw_start,
  input  logic fw_cmd,
  input  die_e fw_die,
  output logic pend_valid,
  output die_e pend_die
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_die   <= DIE_F1;
    end else if (clr) begin
      pend_valid <= 1'b0;
    end else if (fw_start) begin
      pend_valid <= fw_cmd;
      pend_die   <= fw_die;
    end
  end

  // R6: a flash write issued while a pair is open stays on the opening die
  p_pair_same_die_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_start && pend_valid && !clr) |-> (fw_die == pend_die));
endmodule

// File: rtl/msb_wait_norm.sv
module msb_wait_norm
  import msb_pkg::*;
#(
  parameter logic [2:0] POL_RST = 3'b100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  die_e cap_die,
  input  logic cap_bit,
  input  die_e cur_die,
  input  logic burst_on,
  input  logic wait_raw,
  output logic wait_active,
  output logic cfg_mismatch
);
  logic [2:0] pol;

  for (genvar g = 0; g < 3; g++) begin : g_shadow
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= POL_RST[g];
      else if (cap && (cap_die == die_e'(2'(g)))) q <= cap_bit;
    end
    assign pol[g] = q;
  end

  logic cur_pol;
  assign cur_pol      = (cur_die == DIE_NONE) ? 1'b0 : pol[cur_die];
  assign wait_active  = burst_on && (wait_raw == cur_pol);
  assign cfg_mismatch = (pol != 3'b000) && (pol != 3'b111);

  // R10: outside a burst the wait line never stalls anything
  p_wait_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |-> !wait_active);
endmodule

// File: rtl/memstack_bus_ctrl.sv
module memstack_bus_ctrl
  import msb_pkg::*;
#(
  parameter int AW        = 22,
  parameter int DW        = 16,
  parameter int LEN_W     = 8,
  parameter int RAM_ABITS = 21,
  parameter int ACC_CYC   = 2,
  parameter int POL_BIT   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_region,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic             req_cmd,
  input  logic             req_cfg,
  input  logic             req_burst,
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             flash_reset,
  output logic             f_ce1_n,
  output logic             f_ce2_n,
  output logic             f_oe1_n,
  output logic             f_oe2_n,
  output logic             f_we_n,
  output logic             f_rst_n,
  output logic             r_ce_n,
  output logic             r_cre,
  output logic             r_oe_n,
  output logic             r_we_n,
  output logic             r_ub_n,
  output logic             r_lb_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  input  logic [DW-1:0]    dq_in,
  input  logic             mem_wait,
  output logic             wait_active,
  output logic             cfg_mismatch
);
  localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACC_CYC - 1);

  st_e              state;
  die_e             cur_die;
  logic [AW-1:0]    cur_addr;
  logic             cur_write, cur_burst, cur_cfg;
  logic [1:0]       cur_be;
  logic [DW-1:0]    cur_wdata;
  logic [LEN_W-1:0] words_left;
  logic [CW-1:0]    cnt;
  logic             f_rst_q;

  // named internal events
  logic accept, issue, chk_err, fw_start, cfg_cap, pend_valid, act, burst_on;
  die_e chk_die, pend_die;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign issue     = accept && !chk_err;
  assign fw_start  = issue && req_write && is_flash(chk_die);
  assign cfg_cap   = issue && req_write && req_cfg;
  assign act       = (state == ST_ACT);
  assign burst_on  = act && cur_burst && !cur_write;

  msb_req_check #(.AW(AW), .LEN_W(LEN_W), .RAM_ABITS(RAM_ABITS)) u_check (
    .region(req_region), .addr(req_addr), .write(req_write), .len(req_len),
    .pend_valid(pend_valid), .pend_die(pend_die), .flash_held(f_rst_q),
    .die(chk_die), .err(chk_err)
  );

  msb_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .clr(f_rst_q), .fw_start(fw_start),
    .fw_cmd(req_cmd), .fw_die(chk_die),
    .pend_valid(pend_valid), .pend_die(pend_die)
  );

  msb_wait_norm #(.POL_RST(3'b100)) u_wait (
    .clk(clk), .rst_n(rst_n), .cap(cfg_cap), .cap_die(chk_die),
    .cap_bit(req_wdata[POL_BIT]), .cur_die(cur_die), .burst_on(burst_on),
    .wait_raw(mem_wait), .wait_active(wait_active), .cfg_mismatch(cfg_mismatch)
  );

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_die    <= DIE_NONE;
      cur_addr   <= '0;
      cur_write  <= 1'b0;
      cur_burst  <= 1'b0;
      cur_cfg    <= 1'b0;
      cur_be     <= '0;
      cur_wdata  <= '0;
      words_left <= '0;
      cnt        <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      f_rst_q    <= 1'b0;
    end else begin
      f_rst_q   <= flash_reset;
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (chk_err) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else begin
              state      <= ST_ACT;
              cur_die    <= chk_die;
              cur_addr   <= req_addr;
              cur_write  <= req_write;
              cur_burst  <= req_burst;
              cur_cfg    <= req_cfg && req_write;
              cur_be     <= req_be;
              cur_wdata  <= req_wdata;
              words_left <= (req_write || req_len == '0) ? '0 : req_len - 1'b1;
              cnt        <= CNT_LOAD;
            end
          end
        end
        ST_ACT: begin
          if (f_rst_q && is_flash(cur_die)) begin
            state     <= ST_IDLE;
            cur_die   <= DIE_NONE;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else if (wait_active) begin
            cnt <= cnt;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_rdata <= cur_write ? '0 : dq_in;
            if (words_left == '0) begin
              state   <= ST_IDLE;
              cur_die <= DIE_NONE;
            end else begin
              words_left <= words_left - 1'b1;
              cnt        <= CNT_LOAD;
              if (cur_die == DIE_F1 && cur_addr == '1) begin
                cur_die  <= DIE_F2;
                cur_addr <= '0;
                state    <= ST_SPLIT;
              end else begin
                cur_addr <= cur_addr + 1'b1;
              end
            end
          end
        end
        ST_SPLIT: begin
          state <= ST_ACT;
          cnt   <= CNT_LOAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // strobes
  logic on_f1, on_f2, on_ram;
  assign on_f1  = act && (cur_die == DIE_F1) && !f_rst_q;
  assign on_f2  = act && (cur_die == DIE_F2) && !f_rst_q;
  assign on_ram = act && (cur_die == DIE_RAM);

  assign f_ce1_n = !on_f1;
  assign f_ce2_n = !on_f2;
  assign f_oe1_n = !(on_f1 && !cur_write);
  assign f_oe2_n = !(on_f2 && !cur_write);
  assign f_we_n  = !((on_f1 || on_f2) && cur_write);
  assign f_rst_n = !f_rst_q;
  assign r_ce_n  = !on_ram;
  assign r_oe_n  = !(on_ram && !cur_write);
  assign r_we_n  = !(on_ram && cur_write);
  assign r_cre   = on_ram && cur_cfg;
  assign r_ub_n  = on_ram ? (cur_write ? !cur_be[1] : 1'b0) : 1'b1;
  assign r_lb_n  = on_ram ? (cur_write ? !cur_be[0] : 1'b0) : 1'b1;
  assign dq_oe   = (on_f1 || on_f2 || on_ram) && cur_write;
  assign dq_out  = cur_wdata;

  logic [AW-1:0] ram_addr;
  if (RAM_ABITS < AW) begin : g_ram_narrow
    assign ram_addr = {{(AW-RAM_ABITS){1'b0}}, cur_addr[RAM_ABITS-1:0]};
    // R11: upper address bits stay 0 on a smaller RAM
    p_ram_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !r_ce_n |-> (mem_addr[AW-1:RAM_ABITS] == '0));
  end else begin : g_ram_full
    assign ram_addr = cur_addr;
  end

  assign mem_addr = !act ? '0 : (cur_die == DIE_RAM) ? ram_addr : cur_addr;

  // checks over the bus pins
  logic [2:0] sel, prev_sel;
  assign sel = {!r_ce_n, !f_ce2_n, !f_ce1_n};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_sel <= '0;
    else        prev_sel <= sel;
  end

  p_one_die_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_gap_between_dies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sel != '0 && sel != '0) |-> (sel == prev_sel));

  p_flash_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !f_rst_n |-> (f_ce1_n && f_ce2_n && f_we_n));

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_oe1_n || !f_oe2_n || !r_oe_n) |-> (f_we_n && r_we_n && !dq_oe));

  p_err_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> $past(sel == '0));
endmodule

// File: tb/tb_memstack_bus_ctrl.sv
module tb_memstack_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int ACC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_cmd = 0, req_cfg = 0, req_burst = 0;
  logic [1:0] req_region = 0, req_be = 0;
  logic [AW-1:0] req_addr = 0;
  logic [7:0] req_len = 0;
  logic [DW-1:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic flash_reset = 0;
  logic f_ce1_n, f_ce2_n, f_oe1_n, f_oe2_n, f_we_n, f_rst_n;
  logic r_ce_n, r_cre, r_oe_n, r_we_n, r_ub_n, r_lb_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq_out, dq_in;
  logic dq_oe, mem_wait = 1'b1, wait_active, cfg_mismatch;

  always #(CLK_PERIOD/2) clk = ~clk;

  memstack_bus_ctrl #(.AW(AW), .DW(DW), .LEN_W(8), .RAM_ABITS(21), .ACC_CYC(ACC), .POL_BIT(10)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
    .req_addr(req_addr), .req_write(req_write), .req_cmd(req_cmd), .req_cfg(req_cfg),
    .req_burst(req_burst), .req_len(req_len), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .flash_reset(flash_reset), .f_ce1_n(f_ce1_n), .f_ce2_n(f_ce2_n), .f_oe1_n(f_oe1_n),
    .f_oe2_n(f_oe2_n), .f_we_n(f_we_n), .f_rst_n(f_rst_n), .r_ce_n(r_ce_n), .r_cre(r_cre),
    .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .mem_addr(mem_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .mem_wait(mem_wait),
    .wait_active(wait_active), .cfg_mismatch(cfg_mismatch)
  );

  // memory model: each die returns a tag plus the low address bits
  function automatic logic [15:0] patt(input logic [1:0] d, input logic [21:0] a);
    return {d, a[13:0]};
  endfunction

  always_comb begin
    if (!f_ce1_n && !f_oe1_n)      dq_in = patt(2'd0, mem_addr);
    else if (!f_ce2_n && !f_oe2_n) dq_in = patt(2'd1, mem_addr);
    else if (!r_ce_n && !r_oe_n)   dq_in = patt(2'd2, mem_addr);
    else                           dq_in = 16'h0000;
  end

  int n_chk = 0, n_bad = 0;
  int one_viol = 0, gap_viol = 0, rst_viol = 0, bus_act = 0;
  logic [2:0] mon_prev = 3'b000;
  logic mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] s;
      s = {!r_ce_n, !f_ce2_n, !f_ce1_n};
      if ($countones(s) > 1) one_viol++;
      if (mon_prev != 0 && s != 0 && s != mon_prev) gap_viol++;
      if (!f_rst_n && (!f_ce1_n || !f_ce2_n || !f_we_n)) rst_viol++;
      if (s != 0) bus_act++;
      mon_prev = s;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // request driver and response collector
  logic [15:0] rd [0:7];
  logic        er [0:7];
  int nresp, lat;
  logic s_fce1, s_fce2, s_foe1, s_foe2, s_fwe, s_rce, s_roe, s_rwe, s_cre, s_ub, s_lb, s_dqoe;
  logic [21:0] s_addr;
  logic [15:0] s_dq;

  task automatic do_req(input logic [1:0] rg, input logic [21:0] ad, input logic wr,
                        input logic cmd, input logic cfg, input logic bst,
                        input logic [7:0] ln, input logic [1:0] be, input logic [15:0] wd,
                        input int nexp);
    int t;
    bit done;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_region = rg; req_addr = ad; req_write = wr; req_cmd = cmd; req_cfg = cfg;
    req_burst = bst; req_len = ln; req_be = be; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    s_fce1 = f_ce1_n; s_fce2 = f_ce2_n; s_foe1 = f_oe1_n; s_foe2 = f_oe2_n; s_fwe = f_we_n;
    s_rce = r_ce_n; s_roe = r_oe_n; s_rwe = r_we_n; s_cre = r_cre; s_ub = r_ub_n; s_lb = r_lb_n;
    s_dqoe = dq_oe; s_addr = mem_addr; s_dq = dq_out;
    nresp = 0; lat = -1; t = 0; done = 0;
    while (!done) begin
      if (t > 0) @(negedge clk);
      if (rsp_valid) begin
        rd[nresp] = rsp_rdata; er[nresp] = rsp_err;
        if (lat < 0) lat = t + 1;
        nresp++;
        if (rsp_err || nresp >= nexp) done = 1;
      end
      t++;
      if (t > 300) done = 1;
    end
  endtask

  task automatic t_reset_state;
    check(req_ready == 1, "R12 ready after reset", req_ready, 1);
    check({f_ce1_n, f_ce2_n, r_ce_n} == 3'b111, "R12 selects high", {f_ce1_n, f_ce2_n, r_ce_n}, 7);
    check(f_we_n && r_we_n && f_rst_n && !dq_oe, "R12 strobes idle", {f_we_n, r_we_n, f_rst_n, dq_oe}, 4'b1110);
    check(cfg_mismatch == 1, "R9 default polarities differ", cfg_mismatch, 1);
  endtask

  task automatic t_flash_read;
    do_req(2'd0, 22'h000123, 0, 0, 0, 0, 8'd2, 2'b11, 16'h0, 2);
    check({s_fce1, s_foe1, s_fwe, s_fce2, s_rce} == 5'b00111, "R3 lower flash read strobes",
          {s_fce1, s_foe1, s_fwe, s_fce2, s_rce}, 5'b00111);
    check(nresp == 2 && rd[0] == patt(0, 22'h123) && rd[1] == patt(0, 22'h124), "R3 lower flash data",
          {rd[0], rd[1]}, {patt(0, 22'h123), patt(0, 22'h124)});
    do_req(2'd1, 22'h000040, 0, 0, 0, 0, 8'd1, 2'b11, 16'h0, 1);
    check(!s_fce2 && !s_foe2 && s_fce1 && rd[0] == patt(1, 22'h40), "R3 upper flash read",
          rd[0], patt(1, 22'h40));
  endtask

  task automatic t_ram_read;
    do_req(2'd2, 22'h001000, 0, 0, 0, 0, 8'd1, 2'b00, 16'h0, 1);
    check({s_rce, s_roe, s_rwe, s_cre, s_ub, s_lb} == 6'b001000, "R3 RAM read strobes",
          {s_rce, s_roe, s_rwe, s_cre, s_ub, s_lb}, 6'b001000);
    check(rd[0] == patt(2, 22'h1000), "R3 RAM read data", rd[0], patt(2, 22'h1000));
  endtask

  task automatic t_writes;
    do_req(2'd2, 22'h000200, 1, 0, 0, 0, 8'd0, 2'b10, 16'hBEEF, 1);
    check({s_rce, s_rwe, s_roe, s_ub, s_lb, s_dqoe} == 6'b001011, "R4 RAM write strobes",
          {s_rce, s_rwe, s_roe, s_ub, s_lb, s_dqoe}, 6'b001011);
    check(s_dq == 16'hBEEF && s_addr == 22'h200 && !er[0], "R4 RAM write data/addr", {s_dq, s_addr}, {16'hBEEF, 22'h200});
    do_req(2'd1, 22'h000005, 1, 0, 0, 0, 8'd0, 2'b11, 16'h1234, 1);
    check({s_fce2, s_fwe, s_foe2, s_fce1, s_dqoe} == 5'b00111 && s_addr == 22'h5 && s_dq == 16'h1234,
          "R4 flash write strobes", {s_fce2, s_fwe, s_foe2, s_fce1, s_dqoe}, 5'b00111);
  endtask

  task automatic t_errors;
    int b0;
    b0 = bus_act;
    do_req(2'd3, 22'h0, 0, 0, 0, 0, 8'd1, 2'b11, 16'h0, 1);
    check(nresp == 1 && er[0] == 1, "R5 reserved region error", er[0], 1);
    do_req(2'd1, 22'h3FFFFF, 0, 0, 0, 0, 8'd2, 2'b11, 16'h0, 1);
    check(nresp == 1 && er[0] == 1, "R5 read past flash top error", er[0], 1);
    check(bus_act == b0, "R5 errors leave bus idle", bus_act - b0, 0);
  endtask

  task automatic t_ram_range;
    int b0;
    b0 = bus_act;
    do_req(2'd2, 22'h200000, 0, 0, 0, 0, 8'd1, 2'b00, 16'h0, 1);
    check(er[0] == 1 && bus_act == b0, "R11 RAM address above 2M error", er[0], 1);
    do_req(2'd2, 22'h1FFFFF, 0, 0, 0, 0, 8'd2, 2'b00, 16'h0, 1);
    check(er[0] == 1, "R11 RAM run past top error", er[0], 1);
    do_req(2'd2, 22'h1FFFFF, 0, 0, 0, 0, 8'd1, 2'b00, 16'h0, 1);
    check(er[0] == 0 && s_addr == 22'h1FFFFF && rd[0] == patt(2, 22'h1FFFFF), "R11 RAM last word",
          s_addr, 22'h1FFFFF);
  endtask

  task automatic t_pair;
    do_req(2'd0, 22'h000010, 1, 1, 0, 0, 8'd0, 2'b11, 16'h0040, 1);
    check(er[0] == 0, "R6 command setup accepted", er[0], 0);
    do_req(2'd1, 22'h000010, 1, 0, 0, 0, 8'd0, 2'b11, 16'hAAAA, 1);
    check(er[0] == 1, "R6 second half on other die rejected", er[0], 1);
    do_req(2'd0, 22'h000010, 1, 0, 0, 0, 8'd0, 2'b11, 16'h5555, 1);
    check(er[0] == 0 && !s_fce1 && s_dq == 16'h5555, "R6 second half on same die", er[0], 0);
    do_req(2'd1, 22'h000011, 1, 0, 0, 0, 8'd0, 2'b11, 16'h7777, 1);
    check(er[0] == 0, "R6 pair closed, other die free", er[0], 0);
  endtask

  task automatic t_split;
    int g0;
    g0 = gap_viol;
    do_req(2'd0, 22'h3FFFFE, 0, 0, 0, 0, 8'd4, 2'b11, 16'h0, 4);
    check(nresp == 4 && rd[0] == patt(0, 22'h3FFFFE) && rd[1] == patt(0, 22'h3FFFFF) &&
          rd[2] == patt(1, 22'h0) && rd[3] == patt(1, 22'h1), "R7 read restarts on upper die",
          {rd[1], rd[2]}, {patt(0, 22'h3FFFFF), patt(1, 22'h0)});
    check(gap_viol == g0, "R2 deselect cycle at boundary", gap_viol - g0, 0);
  endtask

  task automatic t_cfg;
    do_req(2'd2, 22'h0, 1, 0, 1, 0, 8'd0, 2'b11, 16'h0000, 1);
    check(s_cre == 1 && !s_rce && !s_rwe, "R9 RAM config write enable", s_cre, 1);
    check(cfg_mismatch == 0, "R9 RAM set active-low, match", cfg_mismatch, 0);
    do_req(2'd0, 22'h0, 1, 0, 1, 0, 8'd0, 2'b11, 16'h0400, 1);
    check(cfg_mismatch == 1, "R9 lower flash bit10 set, mismatch", cfg_mismatch, 1);
    do_req(2'd0, 22'h0, 1, 0, 1, 0, 8'd0, 2'b11, 16'h0000, 1);
    check(cfg_mismatch == 0, "R9 lower flash restored", cfg_mismatch, 0);
  endtask

  task automatic t_wait;
    mem_wait = 1'b0; // active level for all dies now
    do_req(2'd2, 22'h000300, 0, 0, 0, 0, 8'd1, 2'b00, 16'h0, 1);
    check(lat == ACC + 1 && rd[0] == patt(2, 22'h300), "R10 wait ignored outside burst", lat, ACC + 1);
    fork
      do_req(2'd2, 22'h000301, 0, 0, 0, 1, 8'd1, 2'b00, 16'h0, 1);
      begin repeat (6) @(negedge clk); mem_wait = 1'b1; end
    join
    check(lat > ACC + 3 && rd[0] == patt(2, 22'h301), "R10 burst held by wait", lat, ACC + 4);
  endtask

  task automatic t_boundary_wait;
    int g0;
    g0 = gap_viol;
    mem_wait = 1'b0;
    fork
      do_req(2'd0, 22'h3FFFFF, 0, 0, 0, 1, 8'd2, 2'b11, 16'h0, 2);
      begin repeat (4) @(negedge clk); mem_wait = 1'b1; end
    join
    check(nresp == 2 && rd[0] == patt(0, 22'h3FFFFF) && rd[1] == patt(1, 22'h0),
          "R7 boundary under wait", {rd[0], rd[1]}, {patt(0, 22'h3FFFFF), patt(1, 22'h0)});
    check(gap_viol == g0 && lat > ACC + 1, "R10 hold before boundary", lat, ACC + 2);
  endtask

  task automatic t_flash_reset;
    do_req(2'd0, 22'h20, 1, 1, 0, 0, 8'd0, 2'b11, 16'h0040, 1);
    @(negedge clk); flash_reset = 1'b1;
    @(negedge clk);
    check(f_rst_n == 0, "R8 reset out one cycle later", f_rst_n, 0);
    do_req(2'd0, 22'h0, 0, 0, 0, 0, 8'd1, 2'b11, 16'h0, 1);
    check(er[0] == 1, "R8 flash request refused in reset", er[0], 1);
    do_req(2'd2, 22'h44, 0, 0, 0, 0, 8'd1, 2'b00, 16'h0, 1);
    check(er[0] == 0 && rd[0] == patt(2, 22'h44), "R8 RAM works during flash reset", rd[0], patt(2, 22'h44));
    @(negedge clk); flash_reset = 1'b0;
    repeat (2) @(negedge clk);
    do_req(2'd1, 22'h20, 1, 0, 0, 0, 8'd0, 2'b11, 16'h1111, 1);
    check(er[0] == 0, "R8 pending pair dropped by reset", er[0], 0);
    mem_wait = 1'b0;
    fork
      do_req(2'd0, 22'h50, 0, 0, 0, 1, 8'd1, 2'b11, 16'h0, 1);
      begin repeat (4) @(negedge clk); flash_reset = 1'b1; end
    join
    check(nresp == 1 && er[0] == 1, "R8 in-flight flash access aborted", er[0], 1);
    mem_wait = 1'b1;
    @(negedge clk); flash_reset = 1'b0;
    repeat (2) @(negedge clk);
    check(rst_viol == 0, "R8 flash strobes quiet in reset", rst_viol, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_flash_read();
    t_ram_read();
    t_writes();
    t_errors();
    t_ram_range();
    t_pair();
    t_split();
    t_cfg();
    t_wait();
    t_boundary_wait();
    t_flash_reset();
    check(one_viol == 0, "R1 single die selected", one_viol, 0);
    check(gap_viol == 0, "R2 no die-to-die handover without gap", gap_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule